// File: doc/BRIEF.md
# Level-Sensitive Interrupt Bank

This block gathers up to 32 level-sensitive interrupt lines into a single register-mapped bank. It produces two request outputs: a normal request and a fast request. Each line first passes through a multi-flop synchroniser into a read-only cause register, which follows the live level of the line. Software never has to acknowledge a source. A source stays visible for as long as its line is held high.

Three enable registers sit next to the cause register and can be reprogrammed at any time. The normal-enable register gates the cause bits onto the normal request output. The fast-enable register gates them onto the fast request output. The endpoint-enable register is a plain stored mask that does not touch either output. Because the two gates are independent, one source can raise the normal request, the fast request or both.

The bank also reports the highest-numbered source that is pending on the normal path, so a handler can service sources from the top bit downwards. To cover more lines, place several banks side by side and give each its own address window.

Top module: `intc_level_bank`

## Requirements
- R1: Out of reset all three enable registers read zero, and `irq_o`, `fiq_o` and `top_vld_o` are low.
- R2: The cause register, read at byte offset 0x0, shows bit n equal to `src_i[n]`. It changes on the second rising clock edge after an input change and not on the first.
- R3: A cause bit stays set while its input stays high, and no bus access clears it.
- R4: A write to offset 0x0 changes neither the cause register nor any enable register.
- R5: The normal-enable register at offset 0x4, the fast-enable register at 0x8 and the endpoint-enable register at 0xC each take the write data on the clock edge where `bus_we` is high. Each reads back that value, with bit n belonging to source n.
- R6: `irq_o` is high exactly when some bit is set in both cause and the normal-enable register.
- R7: `fiq_o` is high exactly when some bit is set in both cause and the fast-enable register, independently of the normal-enable register.
- R8: The endpoint-enable register affects neither `irq_o` nor `fiq_o`.
- R9: When some source is pending on the normal path, `top_vld_o` is 1 and `top_idx_o` is the highest such source number. When no source is pending, `top_vld_o` is 0 and `top_idx_o` is 0.
- R10: Writing zero to the normal-enable register drops `irq_o` from the edge that takes the write, even while inputs stay high.
- R11: Addresses other than 0x0, 0x4, 0x8 and 0xC read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level interrupt lines, asynchronous to clk |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| top_idx_o | output | IDX_W | Highest pending normal-path source |
| top_vld_o | output | 1 | top_idx_o is meaningful |

## Verification
An input change reaches the cause register, both requests and the index after two rising edges. A register write takes effect on the single edge that samples it. Read data is combinational and follows the address within the same cycle. The bench drives every stimulus on a falling edge and samples on a later falling edge. For inputs it checks both one edge after the change (the old value must still show) and two edges after (the new value). For writes it samples one falling edge after the write. Expected cause, pending set and highest index are computed arithmetically from the applied input and mask words, and walking-bit and prefix sweeps cover every source position.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int unsigned OFS_CAUSE  = 0;
   localparam int unsigned OFS_IRQ_EN = 4;
   localparam int unsigned OFS_FIQ_EN = 8;
   localparam int unsigned OFS_EP_EN  = 12;

   typedef enum logic [1:0] {
      SEL_CAUSE = 2'd0,
      SEL_IRQ   = 2'd1,
      SEL_FIQ   = 2'd2,
      SEL_EP    = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic     hit;
      reg_sel_e sel;
   } reg_dec_t;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("intc_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
         end else begin
            stg_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
         end
      end

      assign q_o = stg_q[STAGES-1];
   end

endmodule

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] cause_i,
   output logic [NUM_SRC-1:0] irq_en_o,
   output logic [NUM_SRC-1:0] fiq_en_o,
   output logic [NUM_SRC-1:0] ep_en_o
);

   reg_dec_t           dec;
   logic [NUM_SRC-1:0] irq_en_q, fiq_en_q, ep_en_q;
   logic [NUM_SRC-1:0] wr_val;

   assign wr_val = bus_wdata[NUM_SRC-1:0];

   always_comb begin
      dec.hit = 1'b1;
      dec.sel = SEL_CAUSE;
      if (bus_addr == ADDR_W'(OFS_CAUSE))       dec.sel = SEL_CAUSE;
      else if (bus_addr == ADDR_W'(OFS_IRQ_EN)) dec.sel = SEL_IRQ;
      else if (bus_addr == ADDR_W'(OFS_FIQ_EN)) dec.sel = SEL_FIQ;
      else if (bus_addr == ADDR_W'(OFS_EP_EN))  dec.sel = SEL_EP;
      else                                      dec.hit = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en_q <= '0;
         fiq_en_q <= '0;
         ep_en_q  <= '0;
      end else if (bus_we && dec.hit) begin
         unique case (dec.sel)
            SEL_IRQ:   irq_en_q <= wr_val;
            SEL_FIQ:   fiq_en_q <= wr_val;
            SEL_EP:    ep_en_q  <= wr_val;
            SEL_CAUSE: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (dec.hit) begin
         unique case (dec.sel)
            SEL_CAUSE: bus_rdata = DATA_W'(cause_i);
            SEL_IRQ:   bus_rdata = DATA_W'(irq_en_q);
            SEL_FIQ:   bus_rdata = DATA_W'(fiq_en_q);
            SEL_EP:    bus_rdata = DATA_W'(ep_en_q);
         endcase
      end
   end

   assign irq_en_o = irq_en_q;
   assign fiq_en_o = fiq_en_q;
   assign ep_en_o  = ep_en_q;

endmodule

// File: rtl/intc_pend.sv
module intc_pend
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   localparam int IDX_W  = idx_width(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] cause_i,
   input  logic [NUM_SRC-1:0] irq_en_i,
   input  logic [NUM_SRC-1:0] fiq_en_i,
   output logic               irq_o,
   output logic               fiq_o,
   output logic [IDX_W-1:0]   top_idx_o,
   output logic               top_vld_o
);

   logic [NUM_SRC-1:0] irq_pend, fiq_pend;

   assign irq_pend = cause_i & irq_en_i;
   assign fiq_pend = cause_i & fiq_en_i;
   assign irq_o    = |irq_pend;
   assign fiq_o    = |fiq_pend;

   // ascending scan: the last hit wins, giving the highest set bit
   always_comb begin
      top_idx_o = '0;
      top_vld_o = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (irq_pend[i]) begin
            top_idx_o = IDX_W'(i);
            top_vld_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/intc_level_bank.sv
module intc_level_bank
   import intc_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = idx_width(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o,
   output logic               fiq_o,
   output logic [IDX_W-1:0]   top_idx_o,
   output logic               top_vld_o
);

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_num_src
      $error("intc_level_bank: NUM_SRC must lie in 1..DATA_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("intc_level_bank: ADDR_W must cover offsets up to 0xC");
   end

   logic [NUM_SRC-1:0] cause_w;
   logic [NUM_SRC-1:0] irq_en_w, fiq_en_w, ep_en_w;

   intc_sync #(
      .WIDTH (NUM_SRC),
      .STAGES(SYNC_STAGES)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (src_i),
      .q_o  (cause_w)
   );

   intc_regs #(
      .NUM_SRC(NUM_SRC),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .cause_i  (cause_w),
      .irq_en_o (irq_en_w),
      .fiq_en_o (fiq_en_w),
      .ep_en_o  (ep_en_w)
   );

   intc_pend #(
      .NUM_SRC(NUM_SRC)
   ) i_pend (
      .cause_i  (cause_w),
      .irq_en_i (irq_en_w),
      .fiq_en_i (fiq_en_w),
      .irq_o    (irq_o),
      .fiq_o    (fiq_o),
      .top_idx_o(top_idx_o),
      .top_vld_o(top_vld_o)
   );

endmodule

// File: rtl/intc_level_bank_chk.sv
module intc_level_bank_chk
   import intc_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = idx_width(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_we,
   input logic [NUM_SRC-1:0] wdata,
   input logic               irq_o,
   input logic               fiq_o,
   input logic [IDX_W-1:0]   top_idx_o,
   input logic               top_vld_o,
   input logic [NUM_SRC-1:0] cause,
   input logic [NUM_SRC-1:0] irq_en,
   input logic [NUM_SRC-1:0] fiq_en,
   input logic [NUM_SRC-1:0] ep_en
);

   logic was_rst;

   always_ff @(posedge clk) begin
      was_rst <= !rst_n;
      if (rst_n && was_rst) begin
         // R1: first edge out of reset sees cleared masks and quiet outputs
         a_r1_reset_quiet: assert (irq_en == '0 && fiq_en == '0 && ep_en == '0
                                   && !irq_o && !fiq_o && !top_vld_o);
      end
   end

   if (SYNC_STAGES > 0) begin : g_lag
      logic [NUM_SRC-1:0] mirror_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) mirror_q[k] <= '0;
         end else begin
            mirror_q[0] <= src_i;
            for (int k = 1; k < SYNC_STAGES; k++) mirror_q[k] <= mirror_q[k-1];
         end
      end
      a_r2_cause_lag: assert property (@(posedge clk) disable iff (!rst_n)
         cause == mirror_q[SYNC_STAGES-1]);
   end

   a_r4_cause_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_CAUSE))
      |=> ($stable(irq_en) && $stable(fiq_en) && $stable(ep_en)));

   a_r5_irq_en_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_IRQ_EN)) |=> (irq_en == $past(wdata)));

   a_r6_irq_matches_valid: assert property (@(posedge clk) disable iff (!rst_n)
      top_vld_o == irq_o);

   a_r7_fiq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_en == '0) |-> !fiq_o);

   a_r9_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !top_vld_o |-> (top_idx_o == '0));

   a_r10_irq_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_IRQ_EN) && wdata == '0) |=> !irq_o);

endmodule

bind intc_level_bank intc_level_bank_chk #(
   .NUM_SRC    (NUM_SRC),
   .ADDR_W     (ADDR_W),
   .SYNC_STAGES(SYNC_STAGES)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_i    (src_i),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .wdata    (bus_wdata[NUM_SRC-1:0]),
   .irq_o    (irq_o),
   .fiq_o    (fiq_o),
   .top_idx_o(top_idx_o),
   .top_vld_o(top_vld_o),
   .cause    (cause_w),
   .irq_en   (irq_en_w),
   .fiq_en   (fiq_en_w),
   .ep_en    (ep_en_w)
);

// File: tb/test_intc_level_bank.sv
module test_intc_level_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o, top_vld_o;
   logic [4:0]  top_idx_o;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   intc_level_bank i_intc_level_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_i),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq_o    (irq_o),
      .fiq_o    (fiq_o),
      .top_idx_o(top_idx_o),
      .top_vld_o(top_vld_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [5:0] highest(input logic [31:0] v);
      logic [5:0] r = 6'd0;
      for (int b = 31; b >= 0; b--) if (v[b]) return {1'b1, 5'(b)};
      return r;
   endfunction

   task automatic check_outs(input string req, input logic [31:0] cause,
                             input logic [31:0] ien, input logic [31:0] fen);
      logic [5:0] h;
      h = highest(cause & ien);
      check(req, "irq_o", 32'(irq_o), 32'(|(cause & ien)));
      check(req, "fiq_o", 32'(fiq_o), 32'(|(cause & fen)));
      check(req, "top_vld_o", 32'(top_vld_o), 32'(h[5]));
      check(req, "top_idx_o", 32'(top_idx_o), 32'(h[4:0]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual 200000 cycles expected completion earlier");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] v, prev, pat;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1: reset state
      rd(4'h4, v); check("R1", "irq enable", v, 32'h0);
      rd(4'h8, v); check("R1", "fiq enable", v, 32'h0);
      rd(4'hC, v); check("R1", "ep enable", v, 32'h0);
      check_outs("R1", 32'h0, 32'h0, 32'h0);

      // R5: readback with walking bits and patterns
      for (int n = 0; n < 32; n++) begin
         wr(4'h4, 32'h1 << n);
         wr(4'h8, ~(32'h1 << n));
         wr(4'hC, 32'h8000_0001 ^ (32'h1 << n));
         rd(4'h4, v); check("R5", "irq enable walk", v, 32'h1 << n);
         rd(4'h8, v); check("R5", "fiq enable walk", v, ~(32'h1 << n));
         rd(4'hC, v); check("R5", "ep enable walk", v, 32'h8000_0001 ^ (32'h1 << n));
      end
      wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'hC, 32'h0);

      // R2: two-edge lag for every source position
      prev = 32'h0;
      for (int n = 0; n < 32; n++) begin
         src_i = 32'h1 << n;
         step(1); rd(4'h0, v); check("R2", "cause after one edge", v, prev);
         step(1); rd(4'h0, v); check("R2", "cause after two edges", v, 32'h1 << n);
         prev = 32'h1 << n;
      end

      // R6 / R9: normal path with all enabled, single bits and prefixes
      wr(4'h4, 32'hFFFF_FFFF);
      for (int n = 0; n < 32; n++) begin
         pat = 32'h1 << n;
         src_i = pat; step(2);
         check_outs("R6", pat, 32'hFFFF_FFFF, 32'h0);
         pat = (n == 31) ? 32'hFFFF_FFFF : ((32'h2 << n) - 32'h1);
         src_i = pat; step(2);
         check_outs("R9", pat, 32'hFFFF_FFFF, 32'h0);
      end
      // R9: partial enable hides the top source
      wr(4'h4, 32'h0000_00FF);
      src_i = 32'h8000_0030; step(2);
      check_outs("R9", 32'h8000_0030, 32'h0000_00FF, 32'h0);
      src_i = 32'h8000_0000; step(2);
      check_outs("R9", 32'h8000_0000, 32'h0000_00FF, 32'h0);

      // R10: clearing the normal enable drops the request at once
      wr(4'h4, 32'hFFFF_FFFF);
      src_i = 32'hFFFF_FFFF; step(2);
      check("R10", "irq_o before clear", 32'(irq_o), 32'h1);
      wr(4'h4, 32'h0);
      check_outs("R10", 32'hFFFF_FFFF, 32'h0, 32'h0);

      // R7: fast path independent of normal enable
      wr(4'h8, 32'h0000_0020);
      src_i = 32'h0000_0020; step(2);
      check_outs("R7", 32'h0000_0020, 32'h0, 32'h0000_0020);
      src_i = 32'h0000_0040; step(2);
      check_outs("R7", 32'h0000_0040, 32'h0, 32'h0000_0020);
      wr(4'h4, 32'h0000_0060);
      src_i = 32'h0000_0060; step(2);
      check_outs("R7", 32'h0000_0060, 32'h0000_0060, 32'h0000_0020);
      wr(4'h4, 32'h0); wr(4'h8, 32'h0);

      // R8: endpoint enable alone raises nothing
      wr(4'hC, 32'hFFFF_FFFF);
      src_i = 32'hFFFF_FFFF; step(2);
      check_outs("R8", 32'hFFFF_FFFF, 32'h0, 32'h0);
      wr(4'hC, 32'h0);

      // R3 / R4: cause writes neither clear cause nor touch enables
      wr(4'h4, 32'h0000_1234); wr(4'h8, 32'h0000_5678); wr(4'hC, 32'h0000_9ABC);
      src_i = 32'h0000_0008; step(2);
      wr(4'h0, 32'h0000_0000);
      wr(4'h0, 32'hFFFF_FFFF);
      step(3);
      rd(4'h0, v); check("R3", "cause held high", v, 32'h0000_0008);
      rd(4'h4, v); check("R4", "irq enable untouched", v, 32'h0000_1234);
      rd(4'h8, v); check("R4", "fiq enable untouched", v, 32'h0000_5678);
      rd(4'hC, v); check("R4", "ep enable untouched", v, 32'h0000_9ABC);

      // R11: every unmapped address
      for (int a = 0; a < 16; a++) begin
         if ((a % 4) != 0) begin
            wr(4'(a), 32'hFFFF_FFFF);
            rd(4'(a), v); check("R11", "unmapped read", v, 32'h0);
         end
      end
      rd(4'h4, v); check("R11", "irq enable after stray writes", v, 32'h0000_1234);
      rd(4'h8, v); check("R11", "fiq enable after stray writes", v, 32'h0000_5678);
      rd(4'hC, v); check("R11", "ep enable after stray writes", v, 32'h0000_9ABC);

      // R3: falling input clears cause without software help
      src_i = 32'h0; step(2);
      rd(4'h0, v); check("R3", "cause follows low", v, 32'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule